// File: doc/BRIEF.md
# Calendar Alarm Matcher with Repeat Modes

This block watches the current calendar time (month, day of month, hours, minutes and seconds, all packed BCD) and raises an alarm when that time agrees with five programmable alarm bytes. Each alarm byte carries a skip bit in its top position. Taken together, the five skip bits form a thermometer code that chooses how often the alarm repeats: every second, minute, hour, day, month or year. A code that is not a clean thermometer makes the alarm fire every second, so a bad setting shows up at once.

The comparison runs only when the once-per-second update strobe is high. On a match the block latches an alarm flag. It also drives an active-low interrupt when the interrupt enable is set. While the system runs from its backup supply, the interrupt also needs the backup-alarm enable. Software reaches the five alarm bytes and a read-only flags byte through a small synchronous register port. A read of the flags byte returns the latched flag, then clears the flag and releases the interrupt.

Register map, by byte address: 0 is flags, with the alarm flag in bit 6. Addresses 1 to 5 hold month, date, hour, minute and second. Addresses 6 and 7 read as zero.

Top module: `alarm_match_unit`

## Requirements
- R1: Reset (the power-up event) clears all five alarm bytes, the interrupt enable and the backup-alarm enable. After reset the alarm flag reads 0 and `alarm_irq_n` is 1. An alarm that fires after power-up with the enables still clear only sets the flag.
- R2: A write with `bus_wr` high stores `bus_wdata` at byte address 1 (month), 2 (date), 3 (hour), 4 (minute) or 5 (second). A read with `bus_rd` high places that byte on `bus_rdata` one clock later. Addresses 6 and 7 read 0x00. In every alarm byte, bit 7 is the skip bit for its field. In the month byte, bit 6 is the interrupt enable, bit 5 is the backup-alarm enable and bits 4:0 hold the month.
- R3: The compared widths are month 5 bits, date 6, hour 6, minute 7 and second 7. The legal skip codes, written as {month, date, hour, minute, second} skip bits, are 11111 (every second), 11110 (every minute), 11100 (every hour), 11000 (every day), 10000 (every month) and 00000 (every year). A field whose skip bit is 1 is left out of the comparison.
- R4: Any skip code with a 1 below a 0, reading from the month end toward the second end, is illegal. An illegal code matches on every strobe, as 11111 would.
- R5: The comparison takes effect only on a clock where `sec_tick` is 1. A matching time without the strobe never sets the flag.
- R6: A match sets the alarm flag, which is bit 6 of byte 0, on the clock edge that samples the strobe. On main power (`on_battery` = 0), `alarm_irq_n` goes low at the same edge if the interrupt enable is 1. If the enable is 0, `alarm_irq_n` stays 1.
- R7: A read of byte 0 returns the flag as it was before that read. The same read clears the flag and releases `alarm_irq_n` to 1. A later read returns 0. If a match arrives in the same clock as the read, the match wins.
- R8: With `on_battery` = 1, a match drives `alarm_irq_n` low only when both the interrupt enable and the backup-alarm enable are 1. The flag is set either way.
- R9: A date byte of 0x00 together with an all-zero skip code never matches, which disables the alarm.
- R10: Writes to byte 0 have no effect on the alarm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| sec_tick | input | 1 | Once-per-second update strobe |
| on_battery | input | 1 | 1 while running from the backup supply |
| now_month | input | 8 | Current month, BCD |
| now_date | input | 8 | Current day of month, BCD |
| now_hour | input | 8 | Current hour (24 h), BCD |
| now_minute | input | 8 | Current minute, BCD |
| now_second | input | 8 | Current second, BCD |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| alarm_irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench walks every legal repeat code with one time that should match and one that differs in the first compared field. A design that lost a mask bit, or masked the wrong field, would fire on the non-matching row or stay silent on the matching one. It drives illegal, non-thermometer codes and the disable setting: a design that treated an illegal code literally would miss the every-second fallback, and one that compared the date loosely would fire while the alarm is disabled. It checks the read-to-clear sequence, with the old flag on the first read, zero on the second and the interrupt released in between. A design that cleared the flag before returning it, or left the interrupt asserted, fails there. It also checks the power-state gating, writes to the flags byte, and the absence of any flag without the strobe. A design that ignored the backup enable, let software write the flag, or compared continuously would be caught.

// File: rtl/alarm_pkg.sv
// Package: shared constants and field helpers for the alarm matcher.
// Assumes five calendar fields, indexed from seconds (0) up to month (4).
package alarm_pkg;

    localparam int NUM_FIELDS = 5;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 3;

    // Bit positions inside the alarm bytes and the flags byte.
    localparam int SKIP_BIT   = 7;
    localparam int IRQ_EN_BIT = 6;
    localparam int BAK_EN_BIT = 5;
    localparam int FLAG_BIT   = 6;

    localparam logic [ADDR_W-1:0] ADDR_FLAGS = '0;

    typedef enum int {
        FLD_SEC  = 0,
        FLD_MIN  = 1,
        FLD_HOUR = 2,
        FLD_DATE = 3,
        FLD_MON  = 4
    } field_e;

    // Number of meaningful BCD bits in each field.
    function automatic int field_width(input int idx);
        case (idx)
            FLD_SEC:  return 7;
            FLD_MIN:  return 7;
            FLD_HOUR: return 6;
            FLD_DATE: return 6;
            default:  return 5;
        endcase
    endfunction

    // Byte address of a field: month sits at 1, second at 5.
    function automatic logic [ADDR_W-1:0] field_addr(input int idx);
        return ADDR_W'(NUM_FIELDS - idx);
    endfunction

endpackage

// File: rtl/alarm_regs.sv
// Module: alarm register file and registered read port.
// Holds one byte per calendar field, exposes the two enables from the
// month byte, and returns the alarm flag at the flags address.
// Assumes the read and write strobes last a single clock each.
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic                   rd,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic                   flag,
    output logic [DW-1:0]          rdata,
    output logic [NF-1:0][DW-1:0]  alarm_bytes,
    output logic                   irq_en,
    output logic                   bak_en,
    output logic                   flag_rd
);

    logic [NF-1:0][DW-1:0] alarm_q;
    logic [DW-1:0]         rd_mux;

    // Store each field byte when its address is written.
    generate
        for (genvar i = 0; i < NF; i++) begin : g_byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    alarm_q[i] <= '0;
                end else if (wr && addr == AW'(NF - i)) begin
                    alarm_q[i] <= wdata;
                end
            end
        end
    endgenerate

    // Select the byte for the current read address.
    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_FLAGS) begin
            rd_mux[FLAG_BIT] = flag;
        end
        for (int i = 0; i < NF; i++) begin
            if (addr == AW'(NF - i)) begin
                rd_mux = alarm_q[i];
            end
        end
    end

    // Capture read data on a read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_mux;
        end
    end

    assign alarm_bytes = alarm_q;
    assign irq_en      = alarm_q[FLD_MON][IRQ_EN_BIT];
    assign bak_en      = alarm_q[FLD_MON][BAK_EN_BIT];
    assign flag_rd     = rd && (addr == ADDR_FLAGS);

endmodule

// File: rtl/alarm_compare.sv
// Module: field comparator with thermometer-coded repeat masking.
// Compares only the BCD bits of each field. A skip code with a 1 below
// a 0 (from the month end down) is illegal and masks every field.
module alarm_compare
    import alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = BYTE_W
) (
    input  logic [NF-1:0][DW-1:0] alarm_bytes,
    input  logic [NF-1:0][DW-1:0] now_bytes,
    output logic                  hit
);

    logic [NF-1:0] skip;
    logic [NF-1:0] broken;
    logic [NF-1:0] eff_skip;
    logic [NF-1:0] equal;

    // Per-field skip bit, equality over the field's width, and a code check.
    generate
        for (genvar i = 0; i < NF; i++) begin : g_field
            localparam int            WIDTH = field_width(i);
            localparam logic [DW-1:0] MASK  = DW'((1 << WIDTH) - 1);

            assign skip[i]  = alarm_bytes[i][SKIP_BIT];
            assign equal[i] = ((alarm_bytes[i] ^ now_bytes[i]) & MASK) == '0;

            if (i < NF - 1) begin : g_chk
                assign broken[i] = skip[i] & ~skip[i+1];
            end else begin : g_top
                assign broken[i] = 1'b0;
            end
        end
    endgenerate

    // An illegal code falls back to the every-second setting.
    assign eff_skip = (|broken) ? '1 : skip;
    assign hit      = &(equal | eff_skip);

endmodule

// File: rtl/alarm_flags.sv
// Module: alarm flag and interrupt state.
// Sets on a strobed match; a flags read clears both. A match in the same
// clock as the read takes priority.
module alarm_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic flag_rd,
    input  logic irq_en,
    input  logic bak_en,
    input  logic on_battery,
    output logic flag,
    output logic irq_n
);

    logic event_s;
    logic allow_s;
    logic irq_q;

    assign event_s = tick & hit;
    assign allow_s = irq_en & (~on_battery | bak_en);

    // Latch the alarm flag on a match; release it on a flags read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (event_s) begin
            flag <= 1'b1;
        end else if (flag_rd) begin
            flag <= 1'b0;
        end
    end

    // Latch the interrupt on a permitted match; release it on a flags read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (event_s && allow_s) begin
            irq_q <= 1'b1;
        end else if (flag_rd) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_n = ~irq_q;

endmodule

// File: rtl/alarm_match_unit.sv
// Module: top of the calendar alarm matcher.
// Joins the register file, the comparator and the flag logic. Assumes the
// time inputs are stable in the clock where sec_tick is high.
module alarm_match_unit
    import alarm_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int DW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          on_battery,
    input  logic [DW-1:0] now_month,
    input  logic [DW-1:0] now_date,
    input  logic [DW-1:0] now_hour,
    input  logic [DW-1:0] now_minute,
    input  logic [DW-1:0] now_second,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          alarm_irq_n
);

    logic [NF-1:0][DW-1:0] alarm_bytes_s;
    logic [NF-1:0][DW-1:0] now_bytes_s;
    logic                  hit_s;
    logic                  flag_s;
    logic                  flag_rd_s;
    logic                  irq_en_s;
    logic                  bak_en_s;

    // Gather the time inputs in field order, seconds first.
    assign now_bytes_s = {now_month, now_date, now_hour, now_minute, now_second};

    alarm_regs #(.NF(NF), .DW(DW), .AW(AW)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (bus_wr),
        .rd          (bus_rd),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .flag        (flag_s),
        .rdata       (bus_rdata),
        .alarm_bytes (alarm_bytes_s),
        .irq_en      (irq_en_s),
        .bak_en      (bak_en_s),
        .flag_rd     (flag_rd_s)
    );

    alarm_compare #(.NF(NF), .DW(DW)) i_cmp (
        .alarm_bytes (alarm_bytes_s),
        .now_bytes   (now_bytes_s),
        .hit         (hit_s)
    );

    alarm_flags i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sec_tick),
        .hit        (hit_s),
        .flag_rd    (flag_rd_s),
        .irq_en     (irq_en_s),
        .bak_en     (bak_en_s),
        .on_battery (on_battery),
        .flag       (flag_s),
        .irq_n      (alarm_irq_n)
    );

endmodule

// File: rtl/alarm_match_chk.sv
// Checker: temporal properties of the alarm matcher, bound to its top.
module alarm_match_chk (
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic on_battery,
    input logic hit,
    input logic flag,
    input logic flag_rd,
    input logic irq_en,
    input logic bak_en,
    input logic irq_n
);

    // R5: the flag only rises after a strobed clock.
    assert_flag_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(sec_tick));

    // R7: a flags read without a coincident match clears the flag.
    assert_read_clears_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !(sec_tick && hit)) |=> !flag);

    // R7: a flags read without a coincident match releases the interrupt.
    assert_read_releases_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !(sec_tick && hit)) |=> irq_n);

    // R6: an asserted interrupt always comes with a set flag.
    assert_irq_implies_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> flag);

    // R8: the interrupt only falls when the enables permit it for the power state.
    assert_backup_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(irq_en && (!on_battery || bak_en)));

endmodule

bind alarm_match_unit alarm_match_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .on_battery (on_battery),
    .hit        (hit_s),
    .flag       (flag_s),
    .flag_rd    (flag_rd_s),
    .irq_en     (irq_en_s),
    .bak_en     (bak_en_s),
    .irq_n      (alarm_irq_n)
);

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       on_battery = 1'b0;
    logic [7:0] now_month = '0, now_date = '0, now_hour = '0, now_minute = '0, now_second = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       alarm_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    alarm_match_unit i_alarm_match_unit (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .on_battery(on_battery),
        .now_month(now_month), .now_date(now_date), .now_hour(now_hour),
        .now_minute(now_minute), .now_second(now_second),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq_n(alarm_irq_n)
    );

    // kind: 0 legal code (R3), 1 illegal code (R4), 2 disabled alarm (R9)
    typedef struct packed {
        logic [4:0] rpt;
        logic [7:0] am, ad, ah, ami, as_;
        logic [7:0] cm, cd, ch, cmi, cs;
        logic       exp;
        logic [1:0] kind;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TAB [NV] = '{
        '{5'b00000, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 1'b1, 2'd0},
        '{5'b00000, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h11, 8'h25, 8'h08, 8'h30, 8'h15, 1'b0, 2'd0},
        '{5'b10000, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h11, 8'h25, 8'h08, 8'h30, 8'h15, 1'b1, 2'd0},
        '{5'b10000, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h11, 8'h24, 8'h08, 8'h30, 8'h15, 1'b0, 2'd0},
        '{5'b11000, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h01, 8'h03, 8'h08, 8'h30, 8'h15, 1'b1, 2'd0},
        '{5'b11000, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h01, 8'h03, 8'h09, 8'h30, 8'h15, 1'b0, 2'd0},
        '{5'b11100, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h01, 8'h03, 8'h09, 8'h30, 8'h15, 1'b1, 2'd0},
        '{5'b11100, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h01, 8'h03, 8'h09, 8'h31, 8'h15, 1'b0, 2'd0},
        '{5'b11110, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h01, 8'h03, 8'h09, 8'h31, 8'h15, 1'b1, 2'd0},
        '{5'b11110, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h01, 8'h03, 8'h09, 8'h31, 8'h16, 1'b0, 2'd0},
        '{5'b11111, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h07, 8'h19, 8'h22, 8'h47, 8'h02, 1'b1, 2'd0},
        '{5'b01010, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h07, 8'h19, 8'h22, 8'h47, 8'h02, 1'b1, 2'd1},
        '{5'b00001, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 8'h07, 8'h19, 8'h22, 8'h47, 8'h02, 1'b1, 2'd1},
        '{5'b00000, 8'h12, 8'h00, 8'h08, 8'h30, 8'h15, 8'h12, 8'h25, 8'h08, 8'h30, 8'h15, 1'b0, 2'd2}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input logic [7:0] m, dd, h, mi, s);
        now_month = m; now_date = dd; now_hour = h; now_minute = mi; now_second = s;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // Every field skipped: fires on every strobe. Month byte carries enables.
    task automatic every_second(input logic [1:0] en);
        wr(3'd1, {1'b1, en, 5'h01});
        for (int a = 2; a <= 5; a++) wr(3'(a), 8'h80);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1 irq_n after reset", {7'd0, alarm_irq_n}, 8'h01);
        rd(3'd0, d); check("R1 flags after reset", d, 8'h00);
        rd(3'd1, d); check("R1 month byte after reset", d, 8'h00);
        rd(3'd5, d); check("R1 second byte after reset", d, 8'h00);
        // R9: reset contents form a disabled alarm
        tick(8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        rd(3'd0, d); check("R9 reset contents do not match", d, 8'h00);

        // R2: register access
        wr(3'd5, 8'hD9); rd(3'd5, d); check("R2 second readback", d, 8'hD9);
        wr(3'd3, 8'h23); rd(3'd3, d); check("R2 hour readback", d, 8'h23);
        wr(3'd1, 8'hE9); rd(3'd1, d); check("R2 month readback", d, 8'hE9);
        rd(3'd6, d); check("R2 unmapped address", d, 8'h00);

        // Table: repeat codes on main power with the interrupt enabled
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = (TAB[v].kind == 2'd0) ? "R3" : (TAB[v].kind == 2'd1) ? "R4" : "R9";
            wr(3'd1, {TAB[v].rpt[4], 2'b10, TAB[v].am[4:0]});
            wr(3'd2, {TAB[v].rpt[3], TAB[v].ad[6:0]});
            wr(3'd3, {TAB[v].rpt[2], TAB[v].ah[6:0]});
            wr(3'd4, {TAB[v].rpt[1], TAB[v].ami[6:0]});
            wr(3'd5, {TAB[v].rpt[0], TAB[v].as_[6:0]});
            rd(3'd0, d);
            rd(3'd0, d);
            tick(TAB[v].cm, TAB[v].cd, TAB[v].ch, TAB[v].cmi, TAB[v].cs);
            check($sformatf("%s R6 irq_n row %0d", tag, v), {7'd0, alarm_irq_n}, {7'd0, ~TAB[v].exp});
            rd(3'd0, d);
            check($sformatf("%s flag row %0d", tag, v), d, {1'b0, TAB[v].exp, 6'd0});
        end

        // R7: read returns the old flag, clears it and releases the interrupt
        every_second(2'b10);
        rd(3'd0, d);
        tick(8'h05, 8'h05, 8'h05, 8'h05, 8'h05);
        check("R7 irq asserted before read", {7'd0, alarm_irq_n}, 8'h00);
        rd(3'd0, d); check("R7 first read returns flag", d, 8'h40);
        check("R7 irq released by read", {7'd0, alarm_irq_n}, 8'h01);
        rd(3'd0, d); check("R7 second read returns zero", d, 8'h00);

        // R5: no strobe, no flag, even with a time that matches
        repeat (5) @(negedge clk);
        rd(3'd0, d); check("R5 no flag without strobe", d, 8'h00);
        check("R5 no irq without strobe", {7'd0, alarm_irq_n}, 8'h01);

        // R10: writes to the flags byte are ignored
        wr(3'd0, 8'hFF);
        rd(3'd0, d); check("R10 write cannot set flag", d, 8'h00);
        tick(8'h05, 8'h05, 8'h05, 8'h05, 8'h05);
        wr(3'd0, 8'h00);
        rd(3'd0, d); check("R10 write cannot clear flag", d, 8'h40);

        // R6: enable clear: flag only
        every_second(2'b00);
        tick(8'h05, 8'h05, 8'h05, 8'h05, 8'h05);
        check("R6 irq stays high when disabled", {7'd0, alarm_irq_n}, 8'h01);
        rd(3'd0, d); check("R6 flag set when disabled", d, 8'h40);

        // R8: backup-supply gating
        on_battery = 1'b1;
        every_second(2'b10);
        tick(8'h05, 8'h05, 8'h05, 8'h05, 8'h05);
        check("R8 irq needs backup enable", {7'd0, alarm_irq_n}, 8'h01);
        rd(3'd0, d); check("R8 flag set on backup", d, 8'h40);
        every_second(2'b01);
        tick(8'h05, 8'h05, 8'h05, 8'h05, 8'h05);
        check("R8 irq needs interrupt enable", {7'd0, alarm_irq_n}, 8'h01);
        rd(3'd0, d);
        every_second(2'b11);
        tick(8'h05, 8'h05, 8'h05, 8'h05, 8'h05);
        check("R8 irq with both enables", {7'd0, alarm_irq_n}, 8'h00);
        rd(3'd0, d);
        on_battery = 1'b0;

        // R1: power-up clears the enables; a later alarm sets only the flag
        every_second(2'b11);
        do_reset();
        rd(3'd1, d); check("R1 enables cleared by reset", d, 8'h00);
        check("R1 irq released by reset", {7'd0, alarm_irq_n}, 8'h01);
        wr(3'd1, 8'h81);
        for (int a = 2; a <= 5; a++) wr(3'(a), 8'h80);
        tick(8'h05, 8'h05, 8'h05, 8'h05, 8'h05);
        check("R1 alarm after power-up leaves irq high", {7'd0, alarm_irq_n}, 8'h01);
        rd(3'd0, d); check("R1 alarm after power-up sets flag", d, 8'h40);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule